// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the progressive scan timing for a parallel RGB LCD panel. Software programs the active size, the line and frame totals, the sync pulse widths and a porch offset through a small word-addressed register port. Once the block is running, it counts pixels and lines on the pixel clock. It drives horizontal and vertical sync, a data-enable strobe, and the pixel coordinates inside the visible window. A pixel fetch unit placed downstream uses these outputs to know which pixel to send next.

Each line and each frame starts with its sync pulse. The porch value is measured from the start of the sync pulse to the first visible pixel, so it covers both the sync width and the back porch. Timing fields are double-buffered and take effect only on a frame boundary. The block can raise an interrupt once per frame when the visible region has ended. There are several interrupt channels, each with its own enable and sticky flag. The pad enables for the three timing pins are tristated after reset until software clears the mask.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, data-enable and the interrupt are low. Every register reads back zero, except the tristate mask at address 6, which reads 7.
- R2: While running, a line lasts htotal clocks and a frame lasts vtotal lines, counted from the enabling write. htotal is HTIM (address 2) bits [11:0] and vtotal is VTIM (address 3) bits [11:0]. Both counts restart from pixel 0 of line 0.
- R3: hsync is active during the first hsw clocks of every line. hsw is SYNC (address 4) bits [11:0].
- R4: vsync is active during the first vsw lines of every frame. vsw is SYNC bits [27:16].
- R5: data-enable is high only when the pixel index lies in [hporch, hporch+width) and the line index lies in [vporch, vporch+height). hporch is HTIM bits [27:16], vporch is VTIM bits [27:16], width is RES (address 1) bits [11:0] and height is RES bits [27:16]. pix_x and pix_y give the offset inside that window while data-enable is high, and zero otherwise.
- R6: Setting CTRL (address 0) bit 2 inverts hsync and setting CTRL bit 3 inverts vsync. The inversion also applies while the block is idle.
- R7: Timing runs only while CTRL bit 0 (global) and CTRL bit 1 (channel) are both set. Otherwise the position is held at the origin, both syncs are inactive and data-enable is low.
- R8: A write to a timing field while running is used only from the next frame start. Reads of the field return the newly written value at once.
- R9: Flag k (IRQ register, address 5, bit 16+k) sets on the clock after the position reaches pixel 0 of line vporch+height, but only if enable k (IRQ bit k) is set.
- R10: A write to IRQ loads the enables from bits [NUM_CH-1:0]. Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. irq is the OR of all flags whose enable is set.
- R11: The line delay field, CTRL bits [15:8], is stored saturated at 30 and reads back in the same bits.
- R12: The pin enables are the inverse of the tristate mask bits [2:0]: bit 0 is hsync, bit 1 is vsync and bit 2 is data-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for reg_addr_i, combinational |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable for the visible window |
| pix_x_o | output | CW | Column inside the visible window |
| pix_y_o | output | CW | Row inside the visible window |
| pin_oe_o | output | 3 | Pad output enables for hsync, vsync, data-enable |
| irq_o | output | 1 | Vertical blank interrupt |

## Verification
A corrupted pixel or line counter shifts every later sync edge and data-enable window. The bench compares its own raster model against the outputs on every clock, so such an error shows within one line of the fault. An error in the shadow copy shows only at the next frame start. The bench watches for this by changing a field mid-frame and checking that the first frame keeps the old pulse and the second frame uses the new one. A wrong flag shows on irq in the clock after the blank region starts. It shows in the read-back word right after an acknowledge write.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;
  localparam int unsigned REG_AW    = 3;
  localparam int unsigned HI_LSB    = 16;
  localparam int unsigned DLY_LSB   = 8;
  localparam int unsigned DELAY_MAX = 30;
  localparam int unsigned PIN_CNT   = 3;
  localparam int unsigned NUM_FIELDS = 8;

  // field slots, pairs follow register order (low half, high half)
  localparam int unsigned FI_WID  = 0;
  localparam int unsigned FI_HGT  = 1;
  localparam int unsigned FI_HTOT = 2;
  localparam int unsigned FI_HPOR = 3;
  localparam int unsigned FI_VTOT = 4;
  localparam int unsigned FI_VPOR = 5;
  localparam int unsigned FI_HSW  = 6;
  localparam int unsigned FI_VSW  = 7;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 3'd0,
    RA_RES  = 3'd1,
    RA_HTIM = 3'd2,
    RA_VTIM = 3'd3,
    RA_SYNC = 3'd4,
    RA_IRQ  = 3'd5,
    RA_TRI  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/lcd_tg_regs.sv
`timescale 1ns/1ps
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int unsigned CW     = 12,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DW     = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [REG_AW-1:0]                addr_i,
  input  logic [DW-1:0]                    wdata_i,
  input  logic                             load_i,
  input  logic [NUM_CH-1:0]                flag_i,
  output logic [DW-1:0]                    rdata_o,
  output logic                             glb_en_o,
  output logic                             ch_en_o,
  output logic                             hinv_o,
  output logic                             vinv_o,
  output logic [NUM_FIELDS-1:0][CW-1:0]    act_o,
  output logic [NUM_CH-1:0]                irq_en_o,
  output logic [NUM_CH-1:0]                flag_clr_o,
  output logic [PIN_CNT-1:0]               tri_o
);
  localparam int unsigned DLW   = $clog2(DELAY_MAX + 1);
  localparam int unsigned NPAIR = NUM_FIELDS / 2;

  logic [NUM_FIELDS-1:0][CW-1:0] pend_q, act_q;
  logic                 glb_q, ch_q, hinv_q, vinv_q;
  logic [DLW-1:0]       dly_q;
  logic [NUM_CH-1:0]    ien_q;
  logic [PIN_CNT-1:0]   tri_q;
  logic [7:0]           dly_raw;
  logic                 wr_ctrl, wr_irq, wr_tri;
  logic [1:0]           pair_sel;
  logic                 unused_wdata;

  assign dly_raw      = wdata_i[DLY_LSB +: 8];
  assign wr_ctrl      = we_i && (addr_i == RA_CTRL);
  assign wr_irq       = we_i && (addr_i == RA_IRQ);
  assign wr_tri       = we_i && (addr_i == RA_TRI);
  assign pair_sel     = addr_i[1:0] - 2'd1;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      ch_q   <= 1'b0;
      hinv_q <= 1'b0;
      vinv_q <= 1'b0;
      dly_q  <= '0;
    end else if (wr_ctrl) begin
      glb_q  <= wdata_i[0];
      ch_q   <= wdata_i[1];
      hinv_q <= wdata_i[2];
      vinv_q <= wdata_i[3];
      dly_q  <= (dly_raw > 8'(DELAY_MAX)) ? DLW'(DELAY_MAX) : dly_raw[DLW-1:0];
    end
  end

  // pending timing fields, written as low/high pairs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      for (int p = 0; p < NPAIR; p++) begin
        if (we_i && (addr_i == REG_AW'(int'(RA_RES) + p))) begin
          pend_q[2*p]   <= wdata_i[CW-1:0];
          pend_q[2*p+1] <= wdata_i[HI_LSB +: CW];
        end
      end
    end
  end

  // shadow copy used by the raster, refreshed only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      tri_q <= '1;
    end else begin
      if (wr_irq) ien_q <= wdata_i[NUM_CH-1:0];
      if (wr_tri) tri_q <= wdata_i[PIN_CNT-1:0];
    end
  end

  assign flag_clr_o = wr_irq ? ~wdata_i[HI_LSB +: NUM_CH] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[0] = glb_q;
        rdata_o[1] = ch_q;
        rdata_o[2] = hinv_q;
        rdata_o[3] = vinv_q;
        rdata_o[DLY_LSB +: DLW] = dly_q;
      end
      RA_RES, RA_HTIM, RA_VTIM, RA_SYNC: begin
        rdata_o[CW-1:0]        = pend_q[{pair_sel, 1'b0}];
        rdata_o[HI_LSB +: CW]  = pend_q[{pair_sel, 1'b1}];
      end
      RA_IRQ: begin
        rdata_o[NUM_CH-1:0]       = ien_q;
        rdata_o[HI_LSB +: NUM_CH] = flag_i;
      end
      RA_TRI:  rdata_o[PIN_CNT-1:0] = tri_q;
      default: rdata_o = '0;
    endcase
  end

  assign glb_en_o = glb_q;
  assign ch_en_o  = ch_q;
  assign hinv_o   = hinv_q;
  assign vinv_o   = vinv_q;
  assign act_o    = act_q;
  assign irq_en_o = ien_q;
  assign tri_o    = tri_q;

  // R11: oversize delay saturates
  a_r11_delay_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && (dly_raw > 8'(DELAY_MAX))) |=> (dly_q == DLW'(DELAY_MAX)));

  // R8: shadow moves only on a load
  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/lcd_tg_raster.sv
`timescale 1ns/1ps
module lcd_tg_raster #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] wid_i,
  input  logic [CW-1:0] hgt_i,
  input  logic [CW-1:0] htot_i,
  input  logic [CW-1:0] hpor_i,
  input  logic [CW-1:0] vtot_i,
  input  logic [CW-1:0] vpor_i,
  input  logic [CW-1:0] hsw_i,
  input  logic [CW-1:0] vsw_i,
  input  logic          hinv_i,
  input  logic          vinv_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          load_o,
  output logic          vb_evt_o
);
  logic [CW-1:0] h_q, v_q;
  logic          h_last, v_last, h_act, v_act;
  logic [CW:0]   h_end, v_end;

  assign h_last = (h_q == htot_i - CW'(1));
  assign v_last = (v_q == vtot_i - CW'(1));
  assign h_end  = {1'b0, hpor_i} + {1'b0, wid_i};
  assign v_end  = {1'b0, vpor_i} + {1'b0, hgt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!run_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + CW'(1);
    end else begin
      h_q <= h_q + CW'(1);
    end
  end

  assign h_act = (h_q >= hpor_i) && ({1'b0, h_q} < h_end);
  assign v_act = (v_q >= vpor_i) && ({1'b0, v_q} < v_end);

  assign de_o     = run_i && h_act && v_act;
  assign x_o      = de_o ? h_q - hpor_i : '0;
  assign y_o      = de_o ? v_q - vpor_i : '0;
  assign hsync_o  = (run_i && (h_q < hsw_i)) ^ hinv_i;
  assign vsync_o  = (run_i && (v_q < vsw_i)) ^ vinv_i;
  assign load_o   = !run_i || (h_last && v_last);
  assign vb_evt_o = run_i && (h_q == '0) && ({1'b0, v_q} == v_end);

  // R7: idle holds origin
  a_r7_hold_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((h_q == '0) && (v_q == '0)));

  // R2: pixel count stays inside the line
  a_r2_h_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (htot_i != '0)) |-> (h_q < htot_i));

  // R5: column offset never exceeds the width
  a_r5_x_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (x_o < wid_i));
endmodule

// File: rtl/lcd_tg_irq.sv
`timescale 1ns/1ps
module lcd_tg_irq #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] flag_q;

  // set wins over a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (evt_i && en_i[k]) flag_q[k] <= 1'b1;
        else if (clr_i[k])    flag_q[k] <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R9: a flag rises only with its enable
    a_r9_set_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[k]) |-> $past(en_i[k]));
    // R10: acknowledge without a new event clears
    a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !(evt_i && en_i[k])) |=> !flag_q[k]);
  end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned CW     = 12,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DW     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [CW-1:0]      pix_x_o,
  output logic [CW-1:0]      pix_y_o,
  output logic [PIN_CNT-1:0] pin_oe_o,
  output logic               irq_o
);
  logic                          glb_en, ch_en, hinv, vinv, run, load, vb_evt;
  logic [NUM_FIELDS-1:0][CW-1:0] act;
  logic [NUM_CH-1:0]             irq_en, flag_clr, flags;
  logic [PIN_CNT-1:0]            tri_mask;

  lcd_tg_regs #(.CW(CW), .NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .load_i     (load),
    .flag_i     (flags),
    .rdata_o    (reg_rdata_o),
    .glb_en_o   (glb_en),
    .ch_en_o    (ch_en),
    .hinv_o     (hinv),
    .vinv_o     (vinv),
    .act_o      (act),
    .irq_en_o   (irq_en),
    .flag_clr_o (flag_clr),
    .tri_o      (tri_mask)
  );

  assign run = glb_en && ch_en;

  lcd_tg_raster #(.CW(CW)) u_raster (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .wid_i    (act[FI_WID]),
    .hgt_i    (act[FI_HGT]),
    .htot_i   (act[FI_HTOT]),
    .hpor_i   (act[FI_HPOR]),
    .vtot_i   (act[FI_VTOT]),
    .vpor_i   (act[FI_VPOR]),
    .hsw_i    (act[FI_HSW]),
    .vsw_i    (act[FI_VSW]),
    .hinv_i   (hinv),
    .vinv_i   (vinv),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .x_o      (pix_x_o),
    .y_o      (pix_y_o),
    .load_o   (load),
    .vb_evt_o (vb_evt)
  );

  lcd_tg_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (vb_evt),
    .en_i   (irq_en),
    .clr_i  (flag_clr),
    .flag_o (flags),
    .irq_o  (irq_o)
  );

  assign pin_oe_o = ~tri_mask;
endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  import lcd_tg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hsync, vsync, de, irq;
  logic [11:0] px, py;
  logic [2:0]  oe;

  int n_cmp = 0;
  int n_bad = 0;

  int a[8];
  int p[8];
  bit ih, iv;
  bit [1:0] men, mflag;
  int mh, mv;

  always #5 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .pix_x_o(px), .pix_y_o(py), .pin_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [2:0] ad, input logic [31:0] d);
    if (ad >= 3'd1 && ad <= 3'd4) begin
      p[2*(int'(ad)-1)]   = int'(d[11:0]);
      p[2*(int'(ad)-1)+1] = int'(d[27:16]);
    end
  endfunction

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_wr(ad, d);
  endtask

  task automatic rd(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk);
    addr = ad;
    #1;
    d = rdata;
  endtask

  task automatic start(input logic [31:0] ctrl);
    wr(3'd0, 32'h0);
    wr(3'd0, ctrl | 32'h3);
    mh = 0; mv = 0;
    a = p;
    ih = ctrl[2]; iv = ctrl[3];
  endtask

  // compares every output against the raster model for n clocks
  task automatic scan(input string tag, input int n, input bit dw, input int ws,
                      input logic [2:0] wa, input logic [31:0] wd, output int de_tot);
    int rowcnt = 0;
    de_tot = 0;
    for (int i = 0; i < n; i++) begin
      bit e_de;
      e_de = (mh >= a[3]) && (mh < a[3] + a[0]) && (mv >= a[5]) && (mv < a[5] + a[1]);
      chk({tag, " R3 hsync"}, 32'(hsync), 32'(bit'(mh < a[6]) ^ ih));
      chk({tag, " R4 vsync"}, 32'(vsync), 32'(bit'(mv < a[7]) ^ iv));
      chk({tag, " R5 de"}, 32'(de), 32'(e_de));
      chk({tag, " R2 R5 pix_x"}, 32'(px), e_de ? 32'(mh - a[3]) : 32'h0);
      chk({tag, " R2 R5 pix_y"}, 32'(py), e_de ? 32'(mv - a[5]) : 32'h0);
      chk({tag, " R9 R10 irq"}, 32'(irq), 32'(|(men & mflag)));
      if (de) begin rowcnt++; de_tot++; end
      if (dw && i == ws) begin we = 1'b1; addr = wa; wdata = wd; end
      if (mh == 0 && mv == a[5] + a[1]) mflag |= men;
      if (mh == a[2] - 1) begin
        chk({tag, " R5 de per line"}, 32'(rowcnt),
            ((mv >= a[5]) && (mv < a[5] + a[1])) ? 32'(a[0]) : 32'h0);
        rowcnt = 0;
        mh = 0;
        if (mv == a[4] - 1) begin mv = 0; a = p; end
        else mv++;
      end else begin
        mh++;
      end
      @(negedge clk);
      if (dw && i == ws) begin we = 1'b0; model_wr(wa, wd); end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R1 hsync", 32'(hsync), 0);
    chk("R1 vsync", 32'(vsync), 0);
    chk("R1 de", 32'(de), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 R12 pin_oe", 32'(oe), 0);
    rd(3'd6, d); chk("R1 tri mask", d, 32'h7);
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(3'd5, d); chk("R1 irq reg", d, 32'h0);
    rd(3'd2, d); chk("R1 htim", d, 32'h0);
  endtask

  task automatic t_program();
    wr(3'd1, (32'd8 << 16) | 32'd16);
    wr(3'd2, (32'd5 << 16) | 32'd24);
    wr(3'd3, (32'd3 << 16) | 32'd12);
    wr(3'd4, (32'd2 << 16) | 32'd2);
    wr(3'd6, 32'h0);
    @(negedge clk);
    chk("R12 pin_oe driven", 32'(oe), 32'h7);
    wr(3'd6, 32'h5);
    @(negedge clk);
    chk("R12 pin_oe partial", 32'(oe), 32'h2);
    wr(3'd6, 32'h0);
  endtask

  task automatic t_gate();
    int tot;
    wr(3'd0, 32'h1);
    for (int i = 0; i < 30; i++) begin
      chk("R7 global only hsync", 32'(hsync), 0);
      chk("R7 global only de", 32'(de), 0);
      @(negedge clk);
    end
    wr(3'd0, 32'h2);
    for (int i = 0; i < 30; i++) begin
      chk("R7 channel only vsync", 32'(vsync), 0);
      chk("R7 channel only de", 32'(de), 0);
      @(negedge clk);
    end
    start(32'h0);
    scan("main", 2 * 24 * 12, 1'b0, 0, 3'd0, 32'h0, tot);
    chk("R5 de per two frames", 32'(tot), 32'd256);
    // stop mid-frame, then outputs must idle
    for (int i = 0; i < 100; i++) @(negedge clk);
    wr(3'd0, 32'h1);
    for (int i = 0; i < 10; i++) begin
      chk("R7 stopped hsync", 32'(hsync), 0);
      chk("R7 stopped de", 32'(de), 0);
      chk("R7 stopped pix_y", 32'(py), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_polarity();
    int tot;
    wr(3'd0, 32'hC);
    @(negedge clk);
    chk("R6 idle hsync inverted", 32'(hsync), 1);
    chk("R6 idle vsync inverted", 32'(vsync), 1);
    start(32'hC);
    scan("R6", 24 * 12, 1'b0, 0, 3'd0, 32'h0, tot);
    start(32'h4);
    scan("R6 h only", 24 * 12, 1'b0, 0, 3'd0, 32'h0, tot);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    int tot;
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h0);
    men = 2'b01; mflag = 2'b00;
    wr(3'd5, 32'h1);
    start(32'h0);
    scan("R9", 24 * 12, 1'b0, 0, 3'd0, 32'h0, tot);
    rd(3'd5, d); chk("R9 flag0 set", d, 32'h0001_0001);
    wr(3'd5, 32'h0001_0001);
    rd(3'd5, d); chk("R10 write one keeps flag", d, 32'h0001_0001);
    chk("R10 irq high", 32'(irq), 1);
    wr(3'd5, 32'h1);
    rd(3'd5, d); chk("R10 write zero clears", d, 32'h1);
    chk("R10 irq low after ack", 32'(irq), 0);
    wr(3'd5, 32'h2);
    for (int i = 0; i < 300; i++) @(negedge clk);
    rd(3'd5, d); chk("R9 only enabled channel flags", d, 32'h0002_0002);
    chk("R10 irq ch1", 32'(irq), 1);
    wr(3'd5, 32'h0002_0000);
    rd(3'd5, d); chk("R10 disabled flag kept", d, 32'h0002_0000);
    chk("R10 irq masked", 32'(irq), 0);
    wr(3'd5, 32'h0);
    for (int i = 0; i < 300; i++) @(negedge clk);
    rd(3'd5, d); chk("R9 no flag without enable", d, 32'h0);
    men = 2'b00; mflag = 2'b00;
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    int tot;
    start(32'h0);
    scan("R8", 2 * 24 * 12, 1'b1, 50, 3'd4, (32'd1 << 16) | 32'd4, tot);
    rd(3'd4, d); chk("R8 pending readback", d, (32'd1 << 16) | 32'd4);
  endtask

  task automatic t_delay();
    logic [31:0] d;
    wr(3'd0, 32'd45 << 8);
    rd(3'd0, d); chk("R11 delay 45 saturates", d, 32'd30 << 8);
    wr(3'd0, 32'd17 << 8);
    rd(3'd0, d); chk("R11 delay 17 kept", d, 32'd17 << 8);
    wr(3'd0, 32'd30 << 8);
    rd(3'd0, d); chk("R11 delay 30 kept", d, 32'd30 << 8);
    wr(3'd0, 32'd31 << 8);
    rd(3'd0, d); chk("R11 delay 31 saturates", d, 32'd30 << 8);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin a[i] = 0; p[i] = 0; end
    men = 0; mflag = 0; ih = 0; iv = 0; mh = 0; mv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_gate();
    t_polarity();
    t_irq();
    t_shadow();
    t_delay();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule